// File: doc/BRIEF.md
# Buffered Serial Transmitter with Status Flags

This block serialises words onto an asynchronous serial line. A one-word holding buffer sits in front of a frame shifter. Software can therefore queue the next word while the current frame is still on the wire, and consecutive frames leave with no idle gap between them. An external baud tick sets the bit timing: each bit is held on the line for exactly one tick period. The number of data bits, the parity and the stop length are inputs. The shifter captures them at the moment it takes a word from the buffer.

Two status flags drive two interrupt outputs, and each interrupt has its own enable. The buffer-empty flag raises a level interrupt that stays asserted for as long as the buffer can accept a word. The transmit-done flag is set only when the last stop bit has left the line and no further word is waiting. This suits half-duplex links that must release the bus straight after the final frame. Done is cleared when its interrupt is acknowledged or when software writes a one to clear it.

When the transmit enable is dropped, the block does not stop at once. It keeps sending until both the buffer and the shifter are empty, and only then releases the line.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset the outputs are as follows: `txd_o` is 1, `txd_oe_o` is 0, `buf_empty_o` is 1, and `tx_done_o`, `overrun_o`, `irq_empty_o` and `irq_done_o` are all 0.
- R2: Frame shape and timing:
  - A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then one or two high stop bits.
  - Each bit lasts one baud-tick period, and the idle line is high.
  - `data_bits_i` gives the number of data bits. Values below MIN_BITS are clamped to MIN_BITS, and values above DATA_W are clamped to DATA_W.
- R3: When `par_en_i` is 1, a parity bit is inserted after the last data bit. With `par_odd_i`=0 it is the XOR of the data bits (even parity). With `par_odd_i`=1 it is that XOR inverted.
- R4: Buffer-empty flag and word transfer:
  - `buf_empty_o` falls in the cycle after an accepted write.
  - It rises again when the word moves into the shifter. On an idle line this happens on the next baud tick. Otherwise it happens on the tick that ends the last stop bit, and the next start bit follows with no idle bit.
- R5: `ie_empty_i` and `ie_done_i` are registered when `ctrl_we_i` is 1. `irq_empty_o` is a level: it is 1 whenever `buf_empty_o` is 1 and the empty enable is set.
- R6: `tx_done_o` rises only on the tick that ends a frame's last stop bit while the buffer holds no word. It stays 0 between back-to-back frames.
- R7: Clearing and interrupting on done:
  - `done_ack_i` or `done_w1c_i` clears `tx_done_o`.
  - If a done-set and a clear fall in the same cycle, the set wins.
  - `irq_done_o` is 1 whenever `tx_done_o` is 1 and the done enable is set.
- R8: A write while the buffer is full is ignored and the buffered word is kept. `overrun_o` becomes 1 and stays 1 until reset.
- R9: After `tx_en_i` falls, the buffered and in-flight words are still sent in full. `txd_oe_o` stays 1 until the shifter and the buffer are both empty, then falls one cycle later.
- R10: While the transmitter is disabled:
  - `txd_oe_o` is 0 and `txd_o` is 1.
  - Data writes are ignored, and `buf_empty_o` reads 1.
  - `tx_done_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| tx_en_i | input | 1 | Transmit enable (disable is deferred) |
| data_bits_i | input | CNT_W | Number of data bits per frame |
| par_en_i | input | 1 | Insert parity bit |
| par_odd_i | input | 1 | 0 = even parity, 1 = odd parity |
| two_stop_i | input | 1 | 0 = one stop bit, 1 = two stop bits |
| data_we_i | input | 1 | Write strobe for the holding buffer |
| data_i | input | DATA_W | Word to transmit |
| ctrl_we_i | input | 1 | Write strobe for the interrupt enables |
| ie_empty_i | input | 1 | Buffer-empty interrupt enable value |
| ie_done_i | input | 1 | Transmit-done interrupt enable value |
| done_w1c_i | input | 1 | Write-one-to-clear for the done flag |
| done_ack_i | input | 1 | Done interrupt acknowledge |
| txd_o | output | 1 | Serial line |
| txd_oe_o | output | 1 | Line drive enable |
| buf_empty_o | output | 1 | Holding buffer can take a word |
| tx_done_o | output | 1 | Transmission finished, nothing pending |
| overrun_o | output | 1 | Sticky: write to a full buffer |
| irq_empty_o | output | 1 | Buffer-empty interrupt (level) |
| irq_done_o | output | 1 | Transmit-done interrupt |

## Verification
The bench builds the block with DATA_W=8 and MIN_BITS=5, so `data_bits_i` is four bits wide. That makes a full sweep practical: every data length from 5 to 8, both parity senses with parity on and off, and both stop lengths, with several data words for each. Each expected frame is built bit by bit from the requirement text. The narrow length input also lets the bench drive 3 and 15 to reach both clamp limits. Directed sequences then cover back-to-back transfer, a deferred disable spanning two frames, a done-set colliding with an acknowledge, and the overrun path.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } tx_st_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o
);
  logic              full_q, ovr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, reject;

  assign accept = en_i & we_i & ~full_q;
  assign reject = en_i & we_i & full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
      if (reject) ovr_q <= 1'b1;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign ovr_o  = ovr_q;

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i && !full_o) |=> full_o) else $error("write did not fill"); // R4
  AST_FULL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && full_o) |=> (data_o == $past(data_o))) else $error("full buffer overwritten"); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o) else $error("overrun dropped"); // R8
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] pend_data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              bit_o
);
  tx_st_e            st_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q, nb_q, nb_eff;
  logic              par_q, par_en_q, two_q;
  logic [DATA_W-1:0] mask;
  logic              frame_end;

  always_comb begin
    if (nbits_i < CNT_W'(MIN_BITS))    nb_eff = CNT_W'(MIN_BITS);
    else if (nbits_i > CNT_W'(DATA_W)) nb_eff = CNT_W'(DATA_W);
    else                               nb_eff = nbits_i;
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (CNT_W'(g) < nb_eff);
  end

  assign frame_end = tick_i & ((st_q == ST_STOP2) | ((st_q == ST_STOP1) & ~two_q));
  assign load_o    = tick_i & pend_i & ((st_q == ST_IDLE) | frame_end);
  assign done_o    = frame_end & ~pend_i;
  assign busy_o    = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      nb_q     <= CNT_W'(MIN_BITS);
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      two_q    <= 1'b0;
    end else if (load_o) begin
      st_q     <= ST_START;
      sh_q     <= pend_data_i;
      cnt_q    <= '0;
      nb_q     <= nb_eff;
      par_q    <= (^(pend_data_i & mask)) ^ par_odd_i;
      par_en_q <= par_en_i;
      two_q    <= two_stop_i;
    end else if (tick_i) begin
      unique case (st_q)
        ST_START: st_q <= ST_DATA;
        ST_DATA: begin
          if (cnt_q == nb_q - CNT_W'(1)) begin
            st_q <= par_en_q ? ST_PAR : ST_STOP1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            sh_q  <= sh_q >> 1;
          end
        end
        ST_PAR:   st_q <= ST_STOP1;
        ST_STOP1: st_q <= two_q ? ST_STOP2 : ST_IDLE;
        ST_STOP2: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: bit_o = 1'b0;
      ST_DATA:  bit_o = sh_q[0];
      ST_PAR:   bit_o = par_q;
      default:  bit_o = 1'b1;
    endcase
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (bit_o == 1'b0)) else $error("no start bit after load"); // R2
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (nb_q >= CNT_W'(MIN_BITS) && nb_q <= CNT_W'(DATA_W))) else $error("length out of range"); // R2
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && bit_o)) else $error("line not idle after last frame"); // R6
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic ie_empty_i,
  input  logic ie_done_i,
  input  logic set_done_i,
  input  logic ack_i,
  input  logic w1c_i,
  input  logic empty_i,
  output logic done_o,
  output logic irq_empty_o,
  output logic irq_done_o
);
  logic done_q, ie_empty_q, ie_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      ie_empty_q <= 1'b0;
      ie_done_q  <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        ie_empty_q <= ie_empty_i;
        ie_done_q  <= ie_done_i;
      end
      if (set_done_i)         done_q <= 1'b1;
      else if (ack_i | w1c_i) done_q <= 1'b0;
    end
  end

  assign done_o      = done_q;
  assign irq_empty_o = ie_empty_q & empty_i;
  assign irq_done_o  = ie_done_q & done_q;

  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_done_i |=> done_o) else $error("done not set"); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_i || w1c_i) && !set_done_i) |=> !done_o) else $error("done not cleared"); // R7
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              tx_en_i,
  input  logic [CNT_W-1:0]  data_bits_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_we_i,
  input  logic              ie_empty_i,
  input  logic              ie_done_i,
  input  logic              done_w1c_i,
  input  logic              done_ack_i,
  output logic              txd_o,
  output logic              txd_oe_o,
  output logic              buf_empty_o,
  output logic              tx_done_o,
  output logic              overrun_o,
  output logic              irq_empty_o,
  output logic              irq_done_o
);
  logic              en_q;
  logic              full, take, busy, line_bit, frame_done;
  logic [DATA_W-1:0] pend_data;

  // disable waits for buffer and shifter to drain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= tx_en_i | (en_q & (full | busy));
  end

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .we_i   (data_we_i),
    .data_i (data_i),
    .take_i (take),
    .full_o (full),
    .data_o (pend_data),
    .ovr_o  (overrun_o)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i & en_q),
    .pend_i      (full),
    .pend_data_i (pend_data),
    .nbits_i     (data_bits_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .two_stop_i  (two_stop_i),
    .load_o      (take),
    .done_o      (frame_done),
    .busy_o      (busy),
    .bit_o       (line_bit)
  );

  uart_tx_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ie_empty_i  (ie_empty_i),
    .ie_done_i   (ie_done_i),
    .set_done_i  (frame_done),
    .ack_i       (done_ack_i),
    .w1c_i       (done_w1c_i),
    .empty_i     (buf_empty_o),
    .done_o      (tx_done_o),
    .irq_empty_o (irq_empty_o),
    .irq_done_o  (irq_done_o)
  );

  assign buf_empty_o = ~(en_q & full);
  assign txd_oe_o    = en_q;
  assign txd_o       = en_q ? line_bit : 1'b1;

  AST_DEFER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_oe_o && (!buf_empty_o || busy)) |=> txd_oe_o) else $error("line released early"); // R9
  AST_DONE_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> $past(buf_empty_o)) else $error("done with word pending"); // R6
  AST_OFF_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txd_oe_o && data_we_i) |=> buf_empty_o) else $error("write taken while off"); // R10
endmodule

// File: tb/uart_tx_buf_tb.sv
`timescale 1ns/1ps
module uart_tx_buf_tb;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, tx_en = 0, par_en = 0, par_odd = 0, two_stop = 0;
  logic [CNT_W-1:0] nbits = 4'd8;
  logic we = 0, ctrl_we = 0, ie_e = 0, ie_d = 0, w1c = 0, ack = 0;
  logic [DATA_W-1:0] din = '0;
  logic txd, oe, bempty, done, ovr, irq_e, irq_d;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  uart_tx_buf #(.DATA_W(DATA_W), .MIN_BITS(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .tx_en_i(tx_en),
    .data_bits_i(nbits), .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .data_we_i(we), .data_i(din), .ctrl_we_i(ctrl_we), .ie_empty_i(ie_e), .ie_done_i(ie_d),
    .done_w1c_i(w1c), .done_ack_i(ack), .txd_o(txd), .txd_oe_o(oe), .buf_empty_o(bempty),
    .tx_done_o(done), .overrun_o(ovr), .irq_empty_o(irq_e), .irq_done_o(irq_d)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tk();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin din = d; we = 1; end
    @(negedge clk) we = 0;
  endtask

  task automatic clr_done();
    @(negedge clk) w1c = 1;
    @(negedge clk) w1c = 0;
  endtask

  task automatic grab(input int n, output logic [15:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      tk();
      v[i] = txd;
    end
  endtask

  function automatic logic [15:0] mk(input logic [7:0] d, input int nb, input bit pe, input bit po, input bit ts);
    logic [15:0] f = '0;
    int p = 1;
    bit par = po;
    for (int i = 0; i < nb; i++) begin
      f[p] = d[i];
      par ^= d[i];
      p++;
    end
    if (pe) begin f[p] = par; p++; end
    f[p] = 1'b1; p++;
    if (ts) f[p] = 1'b1;
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] got, ex;
    logic [7:0] d;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({txd, oe, bempty, done, ovr, irq_e, irq_d} == 7'b1010000, "R1 reset",
        {txd, oe, bempty, done, ovr, irq_e, irq_d}, 7'b1010000);

    // R10 disabled: writes ignored, line released
    wr(8'h55);
    chk(bempty == 1 && oe == 0, "R10 write ignored when off", {bempty, oe}, 2'b10);
    tk(); tk();
    chk(txd == 1 && oe == 0, "R10 no frame when off", {txd, oe}, 2'b10);

    // R5 enables and level interrupt
    tx_en = 1;
    @(negedge clk) begin ctrl_we = 1; ie_e = 1; ie_d = 1; end
    @(negedge clk) ctrl_we = 0;
    chk(irq_e == 1, "R5 irq_empty level while empty", irq_e, 1);
    wr(8'h96);
    chk(bempty == 0 && irq_e == 0, "R4 R5 write clears empty", {bempty, irq_e}, 2'b00);
    tk();
    chk(bempty == 1 && irq_e == 1 && txd == 0, "R4 transfer on idle tick", {bempty, irq_e, txd}, 3'b110);
    grab(9, got);
    ex = mk(8'h96, 8, 0, 0, 0) >> 1;
    chk(got == ex, "R2 8N1 frame", got, ex);
    chk(done == 0, "R6 done low in stop bit", done, 0);
    tk();
    chk(done == 1 && irq_d == 1, "R7 done and irq_done", {done, irq_d}, 2'b11);
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
    chk(done == 0 && irq_d == 0, "R7 ack clears done", {done, irq_d}, 2'b00);

    // R2 R3 sweep over length, parity and stop bits
    for (int nb = 5; nb <= 8; nb++)
      for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
          for (int ts = 0; ts < 2; ts++)
            for (int k = 0; k < 3; k++) begin
              d = 8'(nb * 29 + pe * 7 + po * 3 + ts * 11 + k * 85 + 1);
              nbits = CNT_W'(nb); par_en = pe[0]; par_odd = po[0]; two_stop = ts[0];
              wr(d);
              len = 2 + nb + pe + ts;
              grab(len, got);
              ex = mk(d, nb, pe[0], po[0], ts[0]);
              chk(got == ex, "R2 R3 swept frame", got, ex);
              tk();
              chk(done == 1 && txd == 1, "R6 done after frame", {done, txd}, 2'b11);
              clr_done();
              chk(done == 0, "R7 w1c clears done", done, 0);
            end

    // R2 clamping
    par_en = 0; two_stop = 0;
    nbits = 4'd3;
    wr(8'hFF);
    grab(7, got);
    chk(got == mk(8'hFF, 5, 0, 0, 0), "R2 clamp low", got, mk(8'hFF, 5, 0, 0, 0));
    tk(); clr_done();
    nbits = 4'd15;
    wr(8'hB1);
    grab(10, got);
    chk(got == mk(8'hB1, 8, 0, 0, 0), "R2 clamp high", got, mk(8'hB1, 8, 0, 0, 0));
    tk(); clr_done();

    // R4 R6 back-to-back, R7 set beats ack
    nbits = 4'd8;
    wr(8'h3A);
    tk();
    wr(8'hC5);
    chk(bempty == 0, "R4 second word queued", bempty, 0);
    grab(9, got);
    tk();
    chk(txd == 0 && done == 0 && bempty == 1, "R4 R6 next start without gap", {txd, done, bempty}, 3'b001);
    grab(9, got);
    ex = mk(8'hC5, 8, 0, 0, 0) >> 1;
    chk(got == ex, "R4 second frame", got, ex);
    @(negedge clk) begin tick = 1; ack = 1; end
    @(negedge clk) begin tick = 0; ack = 0; end
    chk(done == 1, "R7 set wins over ack", done, 1);
    clr_done();

    // R9 deferred disable over two frames
    wr(8'h81);
    tk();
    wr(8'h7E);
    tx_en = 0;
    @(negedge clk);
    chk(oe == 1, "R9 still driving after disable", oe, 1);
    grab(9, got);
    grab(10, got);
    ex = mk(8'h7E, 8, 0, 0, 0);
    chk(got == ex && oe == 1, "R9 queued frame sent", got, ex);
    tk();
    @(negedge clk);
    chk(oe == 0 && txd == 1, "R9 line released after drain", {oe, txd}, 2'b01);
    chk(done == 1, "R10 done kept while off", done, 1);

    // R8 overrun
    tx_en = 1;
    clr_done();
    chk(ovr == 0, "R8 no overrun yet", ovr, 0);
    wr(8'h5A);
    wr(8'hC3);
    chk(ovr == 1, "R8 overrun set", ovr, 1);
    grab(10, got);
    chk(got == mk(8'h5A, 8, 0, 0, 0), "R8 first word kept", got, mk(8'h5A, 8, 0, 0, 0));
    tk();
    wr(8'h11);
    chk(ovr == 1 && bempty == 0, "R8 overrun sticky", {ovr, bempty}, 2'b10);
    grab(11, got);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule